// File: doc/BRIEF.md
# Privilege Access Filter

This block sits between the system bus and a peripheral's register file and its two memory tables (a command table and a result table). For every access it looks at the word address and the privilege of the bus master. It then either hands the access to the peripheral unchanged, or blocks it. A blocked read gets fixed data back, and a blocked write is dropped without any error.

The address space has two regions.

- **Protected window**: the lowest `FIXED_WORDS` words. It holds the configuration, test and interrupt registers and is always restricted to supervisor mode.
- **Shared window**: every other address, including both tables. One lock bit decides whether user mode may use it.

The lock bit sits at bit `LOCK_BIT` of the configuration register at word address `CFG_ADDR`. The filter keeps its own copy of that bit and shows it on `asgn_locked`. Every path from the address to the peripheral strobes and the read data is combinational. The only state in the block is the lock bit.

Top module: `priv_access_gate`

## Requirements
- R1: When `bus_supv` is 1, any access passes through in the same cycle: `periph_rd` equals `bus_rd`, `periph_wr` equals `bus_wr`, and `bus_rdata` equals `periph_rdata`.
- R2: A user-mode read (`bus_supv`=0) of an address below `FIXED_WORDS` (default 16) returns 16'h0000 and keeps `periph_rd` low.
- R3: While `asgn_locked` is 1, a user-mode read of an address at or above `FIXED_WORDS` returns 16'hFFFF and keeps `periph_rd` low.
- R4: While `asgn_locked` is 0, user-mode reads and writes of the shared window pass through as in R1. This includes the command table (default base 8'h40) and the result table (default base 8'h80).
- R5: A user-mode write to a blocked address keeps `periph_wr` low, so no register is changed.
- R6: After reset, `asgn_locked` is 1.
- R7: A supervisor write to `CFG_ADDR` (default 0) loads `bus_wdata[LOCK_BIT]` (default bit 7) into `asgn_locked`, visible after the next rising clock edge. A user-mode write to `CFG_ADDR` leaves `asgn_locked` unchanged.
- R8: The protected window stays restricted for user mode whatever the value of `asgn_locked`.
- R9: `bus_rdata` follows a change of `periph_rdata` or `bus_addr` in the same cycle, with no register stage in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | AW | Word address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_supv | input | 1 | 1 = master is in supervisor mode |
| bus_rdata | output | DW | Read data returned to the master |
| periph_rdata | input | DW | Read data from the peripheral |
| periph_rd | output | 1 | Read strobe forwarded to the peripheral |
| periph_wr | output | 1 | Write strobe forwarded to the peripheral |
| asgn_locked | output | 1 | 1 = shared window restricted to supervisor mode |

## Verification
Pass-through, substituted read data and strobe suppression are combinational. The bench drives each access on a falling edge and samples one time unit later, inside the same cycle. A change of the lock bit becomes visible only after the rising edge that captures the write. So each configuration write is held across one rising edge, and `asgn_locked` is checked at the following falling edge. The access that depends on the new value is issued only after that check.

// File: rtl/pag_pkg.sv
package pag_pkg;
   typedef enum logic {
      RGN_FIXED = 1'b0,
      RGN_ASGN  = 1'b1
   } pag_region_e;
endpackage

// File: rtl/pag_region_dec.sv
module pag_region_dec
   import pag_pkg::*;
#(
   parameter int AW          = 8,
   parameter int FIXED_WORDS = 16,
   parameter int CFG_ADDR    = 0
) (
   input  logic [AW-1:0] addr,
   output pag_region_e   region,
   output logic          cfg_hit
);
   localparam int FB = (FIXED_WORDS > 1) ? $clog2(FIXED_WORDS) : 1;
   localparam bit POW2 = ((FIXED_WORDS & (FIXED_WORDS - 1)) == 0);

   logic in_fixed;

   if (FIXED_WORDS < 2 || FIXED_WORDS >= (1 << AW)) begin : g_bad_fixed
      $error("FIXED_WORDS must lie in [2, 2**AW)");
   end
   if (CFG_ADDR >= FIXED_WORDS) begin : g_bad_cfg
      $error("CFG_ADDR must fall inside the protected window");
   end

   if (POW2) begin : g_mask_dec
      assign in_fixed = (addr[AW-1:FB] == '0);
   end else begin : g_cmp_dec
      assign in_fixed = (addr < AW'(FIXED_WORDS));
   end

   assign region  = in_fixed ? RGN_FIXED : RGN_ASGN;
   assign cfg_hit = (addr == AW'(CFG_ADDR));
endmodule

// File: rtl/pag_supv_cfg.sv
module pag_supv_cfg #(
   parameter int DW         = 16,
   parameter int LOCK_BIT   = 7,
   parameter bit LOCK_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic          supv,
   input  logic          cfg_hit,
   input  logic [DW-1:0] wdata,
   output logic          locked
);
   if (LOCK_BIT < 0 || LOCK_BIT >= DW) begin : g_bad_bit
      $error("LOCK_BIT outside data word");
   end

   logic locked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     locked_q <= LOCK_RESET;
      else if (wr && supv && cfg_hit) locked_q <= wdata[LOCK_BIT];
   end

   assign locked = locked_q;

   // R6
   lock_reset_chk: assert property (@(posedge clk) !rst_n |=> locked_q == LOCK_RESET);

   // R7
   user_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !supv) |=> $stable(locked_q));
endmodule

// File: rtl/pag_resp_mux.sv
module pag_resp_mux
   import pag_pkg::*;
#(
   parameter int          DW        = 16,
   parameter logic [15:0] FIX_FILL  = 16'h0000,
   parameter logic [15:0] ASGN_FILL = 16'hFFFF
) (
   input  logic          allow,
   input  pag_region_e   region,
   input  logic          rd,
   input  logic          wr,
   input  logic [DW-1:0] periph_rdata,
   output logic [DW-1:0] rdata,
   output logic          periph_rd,
   output logic          periph_wr
);
   localparam logic [DW-1:0] FIX_W  = DW'(FIX_FILL);
   localparam logic [DW-1:0] ASGN_W = DW'(ASGN_FILL);

   logic [DW-1:0] fill;

   always_comb begin
      fill = (region == RGN_FIXED) ? FIX_W : ASGN_W;
      rdata = allow ? periph_rdata : fill;
   end

   assign periph_rd = rd & allow;
   assign periph_wr = wr & allow;
endmodule

// File: rtl/priv_access_gate.sv
module priv_access_gate
   import pag_pkg::*;
#(
   parameter int AW          = 8,
   parameter int DW          = 16,
   parameter int FIXED_WORDS = 16,
   parameter int CFG_ADDR    = 0,
   parameter int LOCK_BIT    = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_rd,
   input  logic          bus_wr,
   input  logic [DW-1:0] bus_wdata,
   input  logic          bus_supv,
   output logic [DW-1:0] bus_rdata,
   input  logic [DW-1:0] periph_rdata,
   output logic          periph_rd,
   output logic          periph_wr,
   output logic          asgn_locked
);
   if (DW < 8 || DW > 16) begin : g_bad_dw
      $error("DW must be 8..16");
   end

   pag_region_e region;
   logic        cfg_hit;
   logic        allow;

   pag_region_dec #(.AW(AW), .FIXED_WORDS(FIXED_WORDS), .CFG_ADDR(CFG_ADDR)) u_dec (
      .addr    (bus_addr),
      .region  (region),
      .cfg_hit (cfg_hit)
   );

   pag_supv_cfg #(.DW(DW), .LOCK_BIT(LOCK_BIT), .LOCK_RESET(1'b1)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .supv    (bus_supv),
      .cfg_hit (cfg_hit),
      .wdata   (bus_wdata),
      .locked  (asgn_locked)
   );

   assign allow = bus_supv | ((region == RGN_ASGN) & ~asgn_locked);

   pag_resp_mux #(.DW(DW)) u_mux (
      .allow        (allow),
      .region       (region),
      .rd           (bus_rd),
      .wr           (bus_wr),
      .periph_rdata (periph_rdata),
      .rdata        (bus_rdata),
      .periph_rd    (periph_rd),
      .periph_wr    (periph_wr)
   );

   // R1
   supv_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_supv |-> (periph_rd == bus_rd && periph_wr == bus_wr && bus_rdata == periph_rdata));

   // R2
   fixed_user_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_supv && bus_rd && bus_addr < AW'(FIXED_WORDS)) |-> (bus_rdata == '0 && !periph_rd));

   // R3
   asgn_user_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_supv && bus_rd && asgn_locked && bus_addr >= AW'(FIXED_WORDS)) |-> (bus_rdata == '1 && !periph_rd));

   // R5
   user_wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_supv && (asgn_locked || bus_addr < AW'(FIXED_WORDS))) |-> !periph_wr);
endmodule

// File: tb/test_priv_access_gate.sv
module test_priv_access_gate;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_rd = 1'b0;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic          bus_supv = 1'b0;
   logic [DW-1:0] bus_rdata;
   logic [DW-1:0] periph_rdata = 16'h1234;
   logic          periph_rd;
   logic          periph_wr;
   logic          asgn_locked;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   priv_access_gate i_priv_access_gate (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_supv(bus_supv),
      .bus_rdata(bus_rdata), .periph_rdata(periph_rdata),
      .periph_rd(periph_rd), .periph_wr(periph_wr), .asgn_locked(asgn_locked)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [7:0] a, input logic rd, input logic wr,
                        input logic [15:0] wd, input logic sv);
      @(negedge clk);
      bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; bus_supv = sv;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      bus_rd = 0; bus_wr = 0; bus_supv = 0;
   endtask

   task automatic t_reset();
      chk("R6 lock after reset", asgn_locked, 1);
   endtask

   task automatic t_user_locked();
      drive(8'h03, 1, 0, 0, 0);
      chk("R2 fixed read data", bus_rdata, 16'h0000);
      chk("R2 fixed read strobe", periph_rd, 0);
      drive(8'h40, 1, 0, 0, 0);
      chk("R3 cmd table read data", bus_rdata, 16'hFFFF);
      chk("R3 cmd table read strobe", periph_rd, 0);
      drive(8'h01, 0, 1, 16'hABCD, 0);
      chk("R5 fixed write blocked", periph_wr, 0);
      drive(8'h80, 0, 1, 16'hABCD, 0);
      chk("R5 result table write blocked", periph_wr, 0);
      idle();
   endtask

   task automatic t_supv_pass();
      drive(8'h02, 1, 0, 0, 1);
      chk("R1 supv read strobe", periph_rd, 1);
      chk("R1 supv read data", bus_rdata, 16'h1234);
      drive(8'h41, 0, 1, 16'h5555, 1);
      chk("R1 supv write strobe", periph_wr, 1);
      idle();
   endtask

   task automatic t_cfg_user();
      drive(8'h00, 0, 1, 16'h0000, 0);
      @(negedge clk);
      bus_wr = 0;
      chk("R7 user cfg write ignored", asgn_locked, 1);
   endtask

   task automatic t_open();
      drive(8'h00, 0, 1, 16'h0000, 1);
      @(negedge clk);
      bus_wr = 0; bus_supv = 0;
      chk("R7 supv cfg write clears lock", asgn_locked, 0);
      drive(8'h85, 1, 0, 0, 0);
      chk("R4 open result read data", bus_rdata, 16'h1234);
      chk("R4 open result read strobe", periph_rd, 1);
      drive(8'h42, 0, 1, 16'h0F0F, 0);
      chk("R4 open cmd write strobe", periph_wr, 1);
      drive(8'h05, 1, 0, 0, 0);
      chk("R8 fixed read stays zero", bus_rdata, 16'h0000);
      drive(8'h02, 0, 1, 16'h0F0F, 0);
      chk("R8 fixed write stays blocked", periph_wr, 0);
      idle();
   endtask

   task automatic t_same_cycle();
      drive(8'h90, 1, 0, 0, 0);
      periph_rdata = 16'hBEEF;
      #1;
      chk("R9 same cycle data", bus_rdata, 16'hBEEF);
      bus_addr = 8'h04;
      #1;
      chk("R9 same cycle region switch", bus_rdata, 16'h0000);
      idle();
   endtask

   task automatic t_relock();
      drive(8'h00, 0, 1, 16'h0080, 1);
      @(negedge clk);
      bus_wr = 0; bus_supv = 0;
      chk("R7 supv cfg write sets lock", asgn_locked, 1);
      drive(8'hC0, 1, 0, 0, 0);
      chk("R3 relocked read data", bus_rdata, 16'hFFFF);
      idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      t_user_locked();
      t_supv_pass();
      t_cfg_user();
      t_open();
      t_same_cycle();
      t_relock();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule